// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This engine moves outgoing frame data from system memory to a MAC-side byte stream under the control of a ring of descriptors that software fills in. Each descriptor starts with a control word that carries an ownership flag, a ring-end flag, a two-bit frame-position code and an interrupt enable. A length word and a buffer-address word follow. The engine fetches these words, reads the buffer one 32-bit word at a time, and sends it out byte by byte. It then hands the descriptor back to software by rewriting its control word with the ownership flag cleared and a byte count as status.

Software loads the ring base, picks a descriptor stride of 16, 32 or 64 bytes (only the first three words carry meaning; the rest is skipped), and writes 11 into the two-bit request field. The engine follows the ring until it fetches a descriptor that software does not own. It then clears the request field and waits. A later start resumes at that same descriptor. Several descriptors can form one frame, so a shared header buffer and separate payload buffers can be chained without copying.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the request field reads 00 and no memory request, stream byte or interrupt is active. Writing 11 to the request field starts fetching at the current descriptor pointer. A ring-base write made while idle sets that pointer. A restart without a base write resumes at the descriptor where the engine last stopped.
- R2: Each descriptor is read at byte offsets 0, 4 and 8. In word 0, bit 31 is the valid flag, bit 30 is ring end, bits 29:28 are the frame position and bit 26 is the interrupt enable. Word 1 bits 31:16 give the buffer length in bytes. Word 2 is the buffer start address.
- R3: When a fetched word 0 has bit 31 clear, the engine sends no bytes, writes nothing, leaves that descriptor untouched and sets the request field to 00.
- R4: Buffer bytes leave in ascending address order from any byte alignment. Byte k of a memory word is bits 8k+7:8k. A byte with tx_valid high is held unchanged until tx_ready is high.
- R5: A frame-position code of 11 marks a whole frame, 10 a first buffer, 00 a middle buffer and 01 a last buffer. tx_sof is high only on the first byte of a 10 or 11 buffer. tx_eof is high only on the last byte of a 01 or 11 buffer.
- R6: Once a buffer has been sent, word 0 of its descriptor is rewritten as follows: bit 31 is 0, bits 30:28 and 26 keep their fetched values, bits 27 and 25:16 are 0, and bits 15:0 hold the buffer length.
- R7: The next descriptor lies 16, 32 or 64 bytes further on when the stride mode is 00, 01 or 10 respectively; mode 11 also gives 64.
- R8: After a descriptor with bit 30 set has been written back, the next fetch is at the ring base.
- R9: If the written-back descriptor had bit 26 set, irq is high for exactly one cycle, the cycle after the write is accepted. Otherwise irq stays low.
- R10: Every memory request is word aligned and holds its address, direction and data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req_we | input | 1 | Write strobe for the request field |
| cfg_req_wdata | input | 2 | Value written to the request field (11 starts) |
| cfg_req_q | output | 2 | Current request field; engine clears it on stop |
| cfg_base_we | input | 1 | Write strobe for the ring base |
| cfg_base_wdata | input | ADDR_W | Ring base address |
| cfg_dmode | input | 2 | Descriptor stride mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| irq | output | 1 | One-cycle write-back interrupt |

## Verification
The engine reacts to a request-field write two edges later: one edge registers the field and the next moves out of idle. Every memory access completes on the edge where mem_ack is high. A stream byte moves on each edge where tx_valid and tx_ready are both high, and irq rises on the edge after the write-back acknowledge. The bench does not predict absolute cycle numbers. It drives tx_ready at the falling edge and records a byte at that same falling edge only if the new ready value and tx_valid are both high, which matches the rising edge that transfers it. It counts irq pulses at falling edges and polls the request field until it returns to 00 before it inspects the stream record and the memory model.

// File: rtl/txd_pkg.sv
// Shared types and helpers for the transmit descriptor engine.
// Assumes descriptor word 1 keeps the length in its upper half.
package txd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_DRD, ST_DTX, ST_WB
    } txd_state_e;

    localparam logic [1:0] REQ_GO = 2'b11;
    localparam int LEN_W = 16;

    // Byte stride of one descriptor for a given mode.
    function automatic logic [6:0] stride_bytes(input logic [1:0] mode);
        case (mode)
            2'b00:   return 7'd16;
            2'b01:   return 7'd32;
            default: return 7'd64;
        endcase
    endfunction
endpackage

// File: rtl/txd_regs.sv
// Software-visible request field and ring base register.
// Assumes a software write and an engine stop in the same cycle resolve to
// the software value.
module txd_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [1:0]        req_wdata,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              stop,
    output logic [1:0]        req_q,
    output logic [ADDR_W-1:0] base_q
);
    // Request field: software sets, engine clears on stop.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= 2'b00;
        else if (req_we)  req_q <= req_wdata;
        else if (stop)    req_q <= 2'b00;
    end

    // Ring base: wrap target for ring-end descriptors.
    always_ff @(posedge clk) begin
        if (!rst_n)        base_q <= '0;
        else if (base_we)  base_q <= base_wdata;
    end
endmodule

// File: rtl/txd_lane.sv
// Picks one byte lane out of a memory word (lane k = bits 8k+7:8k).
// Assumes little-endian lane order.
module txd_lane #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]          word,
    input  logic [$clog2(WORD_W/8)-1:0] sel,
    output logic [7:0]                 byte_o
);
    localparam int NLANE = WORD_W / 8;
    logic [7:0] lanes [NLANE];

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            assign lanes[g] = word[8*g +: 8];
        end
    endgenerate

    assign byte_o = lanes[sel];
endmodule

// File: rtl/txd_engine.sv
// Descriptor walker: fetches three descriptor words, streams the buffer,
// writes the control word back and steps or wraps the ring pointer.
// Assumes the memory slave holds mem_ack for one cycle per request.
module txd_engine
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [1:0]        dmode,
    output logic              stop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       word_q,
    output logic [1:0]        lane_sel,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              irq
);
    txd_state_e        state;
    logic [ADDR_W-1:0] ptr, cur;
    logic              ring_end, ie, first;
    logic [1:0]        fpos;
    logic [LEN_W-1:0]  len, remain;

    // Memory request decode per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = {1'b0, ring_end, fpos, 1'b0, ie, {(26-LEN_W){1'b0}}, len};
        case (state)
            ST_RD0: begin mem_req = 1'b1; mem_addr = ptr; end
            ST_RD1: begin mem_req = 1'b1; mem_addr = ptr + ADDR_W'(4); end
            ST_RD2: begin mem_req = 1'b1; mem_addr = ptr + ADDR_W'(8); end
            ST_DRD: begin mem_req = 1'b1; mem_addr = {cur[ADDR_W-1:2], 2'b00}; end
            ST_WB:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr; end
            default: ;
        endcase
    end

    // Stream side outputs.
    assign tx_valid = (state == ST_DTX);
    assign tx_sof   = tx_valid && first && fpos[1];
    assign tx_eof   = tx_valid && (remain == LEN_W'(1)) && fpos[0];
    assign lane_sel = cur[1:0];
    assign stop     = (state == ST_RD0) && mem_ack && !mem_rdata[31];

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; ptr <= '0; cur <= '0; word_q <= '0;
            ring_end <= 1'b0; ie <= 1'b0; fpos <= 2'b00; first <= 1'b0;
            len <= '0; remain <= '0; irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (base_we) ptr <= base_wdata;
                    if (go)      state <= ST_RD0;
                end
                ST_RD0: if (mem_ack) begin
                    if (!mem_rdata[31]) state <= ST_IDLE;
                    else begin
                        ring_end <= mem_rdata[30];
                        fpos     <= mem_rdata[29:28];
                        ie       <= mem_rdata[26];
                        state    <= ST_RD1;
                    end
                end
                ST_RD1: if (mem_ack) begin
                    len    <= mem_rdata[31:16];
                    remain <= mem_rdata[31:16];
                    state  <= ST_RD2;
                end
                ST_RD2: if (mem_ack) begin
                    cur   <= mem_rdata[ADDR_W-1:0];
                    first <= 1'b1;
                    state <= (remain == '0) ? ST_WB : ST_DRD;
                end
                ST_DRD: if (mem_ack) begin
                    word_q <= mem_rdata;
                    state  <= ST_DTX;
                end
                ST_DTX: if (tx_ready) begin
                    first  <= 1'b0;
                    cur    <= cur + ADDR_W'(1);
                    remain <= remain - LEN_W'(1);
                    if (remain == LEN_W'(1))  state <= ST_WB;
                    else if (cur[1:0] == 2'b11) state <= ST_DRD;
                end
                ST_WB: if (mem_ack) begin
                    irq   <= ie;
                    ptr   <= ring_end ? ring_base : ptr + ADDR_W'(stride_bytes(dmode));
                    state <= go ? ST_RD0 : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txdesc_dma.sv
// Top of the transmit descriptor engine: registers, sequencer, byte lane.
// Assumes a single-outstanding 32-bit memory slave with a req/ack handshake.
module txdesc_dma
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req_we,
    input  logic [1:0]        cfg_req_wdata,
    output logic [1:0]        cfg_req_q,
    input  logic              cfg_base_we,
    input  logic [ADDR_W-1:0] cfg_base_wdata,
    input  logic [1:0]        cfg_dmode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              irq
);
    logic              stop;
    logic [ADDR_W-1:0] base_q;
    logic [31:0]       word_q;
    logic [1:0]        lane_sel;

    txd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_we(cfg_req_we), .req_wdata(cfg_req_wdata),
        .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
        .stop(stop), .req_q(cfg_req_q), .base_q(base_q)
    );

    txd_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(cfg_req_q == REQ_GO),
        .base_we(cfg_base_we), .base_wdata(cfg_base_wdata),
        .ring_base(base_q), .dmode(cfg_dmode), .stop(stop),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .word_q(word_q), .lane_sel(lane_sel),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_sof(tx_sof), .tx_eof(tx_eof), .irq(irq)
    );

    txd_lane #(.WORD_W(32)) u_lane (
        .word(word_q), .sel(lane_sel), .byte_o(tx_data)
    );
endmodule

// File: rtl/txd_checker.sv
// Protocol checks for txdesc_dma, bound to every instance of the top.
module txd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req_we,
    input logic [1:0]        cfg_req_q,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic [31:0]       mem_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_sof,
    input logic              tx_eof,
    input logic              irq
);
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));  // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R10
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));  // R4
    AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sof || tx_eof) |-> tx_valid);  // R5
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!mem_wdata[31] && !mem_wdata[27]));  // R6
    AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_req && mem_we && mem_ack));  // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);  // R9
    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_req_q == 2'b00) && $past(cfg_req_q == 2'b11) && !$past(cfg_req_we))
        |-> $past(mem_req && !mem_we && mem_ack && !mem_rdata[31]));  // R3
endmodule

bind txdesc_dma txd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req_we(cfg_req_we), .cfg_req_q(cfg_req_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .irq(irq)
);

// File: tb/txdesc_dma_test.sv
// Directed bench: word-array memory model, stalling byte sink, reference queue.
module txdesc_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req_we = 1'b0;
    logic [1:0]  cfg_req_wdata = 2'b00;
    logic [1:0]  cfg_req_q;
    logic        cfg_base_we = 1'b0;
    logic [31:0] cfg_base_wdata = '0;
    logic [1:0]  cfg_dmode = 2'b00;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_sof, tx_eof, irq;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    int checks = 0, errors = 0, irq_cnt = 0, misalign = 0, cyc = 0;
    logic [31:0] mem [0:511];
    logic [9:0]  got [$];
    logic [9:0]  exp [$];

    always #4 clk = ~clk;  // 125 MHz

    txdesc_dma uut (.*);

    // Memory model: one ack per request, the cycle after it appears.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end else mem_ack <= 1'b0;
    end

    // Sink: set ready, then log the byte the coming edge transfers.
    always @(negedge clk) begin
        cyc++;
        tx_ready = (cyc % 5 != 2) && (cyc % 11 != 7);
        if (rst_n && tx_valid && tx_ready) got.push_back({tx_sof, tx_eof, tx_data});
        if (rst_n && irq) irq_cnt++;
        if (rst_n && mem_req && mem_addr[1:0] != 2'b00) misalign++;
    end

    function automatic logic [7:0] bpat(input int a);
        return 8'(a * 13 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic set_desc(input int a, input logic [31:0] w0, input int len, input int b);
        mem[a/4] = w0; mem[a/4+1] = {16'(len), 16'h0}; mem[a/4+2] = 32'(b);
    endtask

    task automatic expect_buf(input int b, input int len, input logic [1:0] fp);
        for (int i = 0; i < len; i++)
            exp.push_back({(i == 0) && fp[1], (i == len-1) && fp[0], bpat(b + i)});
    endtask

    task automatic set_base(input int a);
        @(negedge clk); cfg_base_we = 1'b1; cfg_base_wdata = 32'(a);
        @(negedge clk); cfg_base_we = 1'b0;
    endtask

    task automatic run_ring();
        got.delete(); irq_cnt = 0;
        @(negedge clk); cfg_req_we = 1'b1; cfg_req_wdata = 2'b11;
        @(negedge clk); cfg_req_we = 1'b0;
        repeat (2) @(negedge clk);
        while (cfg_req_q != 2'b00) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic cmp_stream(input string tag);
        int bad_d = -1, bad_m = -1;
        chk(got.size() == exp.size(), "R4", {tag, " byte count"}, got.size(), exp.size());
        for (int i = 0; i < got.size() && i < exp.size(); i++) begin
            if (bad_d < 0 && got[i][7:0] != exp[i][7:0]) bad_d = i;
            if (bad_m < 0 && got[i][9:8] != exp[i][9:8]) bad_m = i;
        end
        chk(bad_d < 0, "R4", {tag, " data"}, bad_d < 0 ? 0 : got[bad_d], bad_d < 0 ? 0 : exp[bad_d]);
        chk(bad_m < 0, "R5", {tag, " sof/eof"}, bad_m < 0 ? 0 : got[bad_m], bad_m < 0 ? 0 : exp[bad_m]);
        exp.delete();
    endtask

    task automatic t_reset();
        chk(cfg_req_q == 2'b00, "R1", "reset req field", cfg_req_q, 0);
        chk(!mem_req && !tx_valid && !irq, "R1", "reset idle", {mem_req, tx_valid, irq}, 0);
    endtask

    // Single-buffer frame, 16-byte stride, unaligned buffer, then resume.
    task automatic t_single();
        cfg_dmode = 2'b00;
        set_desc(32'h000, 32'hB400_0000, 5, 32'h201);
        set_desc(32'h010, 32'h0, 0, 0);
        set_base(32'h000);
        expect_buf(32'h201, 5, 2'b11);
        run_ring();
        cmp_stream("single");
        chk(mem[0] == 32'h3400_0005, "R6", "single write-back", mem[0], 32'h3400_0005);
        chk(mem[1] == 32'h0005_0000, "R2", "length word untouched", mem[1], 32'h0005_0000);
        chk(irq_cnt == 1, "R9", "single irq count", irq_cnt, 1);
        chk(mem[4] == 32'h0, "R3", "invalid desc untouched", mem[4], 0);
        chk(cfg_req_q == 2'b00, "R3", "req cleared", cfg_req_q, 0);
        set_desc(32'h010, 32'hB000_0000, 2, 32'h300);
        set_desc(32'h020, 32'h0, 0, 0);
        expect_buf(32'h300, 2, 2'b11);
        run_ring();
        cmp_stream("resume R1");
        chk(mem[4] == 32'h3000_0002, "R1", "resume write-back", mem[4], 32'h3000_0002);
        chk(irq_cnt == 0, "R9", "no irq when disabled", irq_cnt, 0);
    endtask

    // Three-buffer frame with 32-byte stride.
    task automatic t_multi();
        cfg_dmode = 2'b01;
        set_desc(32'h080, 32'hA000_0000, 3, 32'h400);
        set_desc(32'h0A0, 32'h8000_0000, 4, 32'h410);
        set_desc(32'h0C0, 32'h9000_0000, 2, 32'h422);
        set_desc(32'h0E0, 32'h0, 0, 0);
        set_base(32'h080);
        expect_buf(32'h400, 3, 2'b10);
        expect_buf(32'h410, 4, 2'b00);
        expect_buf(32'h422, 2, 2'b01);
        run_ring();
        cmp_stream("multi R7");
        chk(mem[32'h80/4] == 32'h2000_0003, "R6", "first wb", mem[32'h80/4], 32'h2000_0003);
        chk(mem[32'hA0/4] == 32'h0000_0004, "R6", "middle wb", mem[32'hA0/4], 32'h0000_0004);
        chk(mem[32'hC0/4] == 32'h1000_0002, "R7", "last wb at stride", mem[32'hC0/4], 32'h1000_0002);
    endtask

    // Ring-end wrap with 64-byte stride; a trap descriptor follows.
    task automatic t_wrap();
        cfg_dmode = 2'b10;
        set_desc(32'h100, 32'hF400_0000, 6, 32'h500);
        set_desc(32'h140, 32'hB000_0000, 2, 32'h600);
        set_base(32'h100);
        expect_buf(32'h500, 6, 2'b11);
        run_ring();
        cmp_stream("wrap R8");
        chk(mem[32'h100/4] == 32'h7400_0006, "R6", "ring-end wb", mem[32'h100/4], 32'h7400_0006);
        chk(mem[32'h140/4] == 32'hB000_0000, "R8", "trap untouched", mem[32'h140/4], 32'hB000_0000);
        chk(irq_cnt == 1, "R9", "wrap irq", irq_cnt, 1);
    endtask

    // Invalid first descriptor.
    task automatic t_invalid();
        cfg_dmode = 2'b00;
        set_desc(32'h180, 32'h3400_0000, 4, 32'h700);
        set_base(32'h180);
        run_ring();
        chk(got.size() == 0, "R3", "no bytes", got.size(), 0);
        chk(mem[32'h180/4] == 32'h3400_0000, "R3", "no write", mem[32'h180/4], 32'h3400_0000);
        chk(irq_cnt == 0, "R3", "no irq", irq_cnt, 0);
        chk(misalign == 0, "R10", "aligned requests", misalign, 0);
    endtask

    initial begin
        for (int w = 0; w < 512; w++)
            mem[w] = {bpat(4*w+3), bpat(4*w+2), bpat(4*w+1), bpat(4*w)};
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_wrap();
        t_invalid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule